// File: doc/BRIEF.md
# Vertical-Sync Committed Video Control Registers

This block holds the configuration that a video scaler and deinterlacer front end reads while a frame is in flight. Software programs working copies of the configuration over a plain 32-bit register bus with combinational read data. The outputs that steer the datapath never follow those writes directly. They come from a second, active copy.

The active copy is reloaded only when two things are true: software has armed a self-clearing commit request, and a rising edge of vertical sync arrives. The vertical sync input is treated as asynchronous. It is passed through a synchroniser chain and edge-detected, which yields a single-cycle commit pulse.

A field register serves two roles, chosen by the active live-field mode bit:
- When the mode bit is set, reading the field register returns the synchronised field parity from the timing logic. The field-select output also follows that parity.
- When the mode bit is clear, software chooses the field itself, and the committed choice drives the field-select output.

Top module: `vid_cfg_shadow_regs`

## Requirements
- R1: While reset is asserted and right after it, every active output, the field select and every readback are 0.
- R2: The mode register at byte offset 0x10 uses four bits. Bit 5 is line skip (1 = the DMA fetches every second line). Bit 4 is memory layout (0 = linear, 1 = 2D tile). Bit 3 is chroma source (0 = top chroma pointer only, 1 = top and bottom pointers). Bit 2 is live-field mode. All other bits read 0, and writes to them are ignored.
- R3: A write to the mode or field register shows in the readback on the next cycle. The active outputs keep their value until a commit.
- R4: Writing 1 to bit 0 of offset 0x08 arms the commit request. Writing 0 there has no effect. The offset always reads 0.
- R5: A low-to-high transition on vsync_in is seen as the commit point at the third rising clock edge after it is sampled. At that point, if the request is armed, the active copy takes the working values and the request clears.
- R6: A vsync rising edge with no armed request leaves every active output unchanged.
- R7: A request write in the same cycle as a commit stays armed, and it takes effect at the following vsync rising edge.
- R8: The field register is bit 0 of offset 0x0C, where 0 = top and 1 = bottom. If the active live-field bit is 1, the register reads the parity input delayed by two clock edges, and field_sel follows that same value. Otherwise the register reads the last written value, and field_sel gives the committed written value.
- R9: Reads of any offset other than 0x0C and 0x10 return 0. Writes to unmapped offsets change nothing.
- R10: vsync_in held high for many cycles produces exactly one commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| vsync_in | input | 1 | Asynchronous vertical sync |
| field_parity_in | input | 1 | Asynchronous live field parity (1 = bottom) |
| cfg_line_skip | output | 1 | Active line-skip enable |
| cfg_tile_mode | output | 1 | Active memory layout (1 = 2D tile) |
| cfg_chroma_both | output | 1 | Active chroma source (1 = both pointers) |
| cfg_field_live | output | 1 | Active live-field mode |
| field_sel | output | 1 | Field the datapath uses (1 = bottom) |

## Verification
The hardest case to reach is a request write that lands in exactly the cycle of the commit pulse. The pulse appears only after a synchronisation delay that cannot be seen at the ports. The stimulus raises vsync just after a clock edge, lets two more edges pass, and then drives the request write for one cycle, so that it coincides with the commit edge. A second vsync edge then shows that the request survived. Random bursts of writes mixed with vsync and parity toggles also hit this overlap by chance, and a reference model in the bench checks them on every cycle.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

    // Field order matches the bit order in the mode register (MSB first).
    typedef struct packed {
        logic line_skip;
        logic tile_mode;
        logic chroma_both;
        logic field_live;
    } mode_t;

    typedef struct packed {
        mode_t mode;
        logic  field_bot;
    } cfg_t;

    localparam int MODE_W   = $bits(mode_t);
    localparam int MODE_LSB = 2;

endpackage

// File: rtl/vcs_sync_edge.sv
module vcs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    input  logic parity_in,
    output logic commit,
    output logic parity_sync
);
    typedef struct packed {
        logic [STAGES-1:0] vs;
        logic [STAGES-1:0] pf;
        logic              vs_prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.vs      = {st_q.vs[STAGES-2:0], vsync_in};
        st_d.pf      = {st_q.pf[STAGES-2:0], parity_in};
        st_d.vs_prev = st_q.vs[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit      = st_q.vs[STAGES-1] & ~st_q.vs_prev;
    assign parity_sync = st_q.pf[STAGES-1];
endmodule

// File: rtl/vcs_cfg_bank.sv
module vcs_cfg_bank
    import vcs_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] OFS_REQ   = 8'h08,
    parameter logic [ADDR_W-1:0] OFS_FIELD = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_MODE  = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    output cfg_t              work,
    output cfg_t              active,
    output logic              req_pend
);
    typedef struct packed {
        cfg_t work;
        cfg_t act;
        logic req;
    } bank_t;

    bank_t bk_d, bk_q;
    logic  req_set;
    logic  unused_wbits;

    assign unused_wbits = ^{wdata[DATA_W-1:MODE_LSB+MODE_W], wdata[MODE_LSB-1:1]};

    always_comb begin
        bk_d    = bk_q;
        req_set = wr_en && (addr == OFS_REQ) && wdata[0];
        if (wr_en && addr == OFS_MODE)
            bk_d.work.mode = mode_t'(wdata[MODE_LSB +: MODE_W]);
        if (wr_en && addr == OFS_FIELD)
            bk_d.work.field_bot = wdata[0];
        if (commit && bk_q.req)
            bk_d.act = bk_q.work;
        // a request written during the commit cycle survives to the next edge
        bk_d.req = commit ? req_set : (bk_q.req | req_set);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign work     = bk_q.work;
    assign active   = bk_q.act;
    assign req_pend = bk_q.req;
endmodule

// File: rtl/vcs_read_mux.sv
module vcs_read_mux
    import vcs_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] OFS_FIELD = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_MODE  = 8'h10
) (
    input  logic [ADDR_W-1:0] addr,
    input  cfg_t              work,
    input  logic              live_mode,
    input  logic              parity_sync,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (addr == OFS_MODE)
            rdata[MODE_LSB +: MODE_W] = work.mode;
        else if (addr == OFS_FIELD)
            rdata[0] = live_mode ? parity_sync : work.field_bot;
    end
endmodule

// File: rtl/vid_cfg_shadow_regs.sv
module vid_cfg_shadow_regs
    import vcs_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] OFS_REQ     = 8'h08,
    parameter logic [ADDR_W-1:0] OFS_FIELD   = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_MODE    = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              vsync_in,
    input  logic              field_parity_in,
    output logic              cfg_line_skip,
    output logic              cfg_tile_mode,
    output logic              cfg_chroma_both,
    output logic              cfg_field_live,
    output logic              field_sel
);
    logic commit;
    logic parity_sync;
    logic req_pend;
    cfg_t work;
    cfg_t active;

    vcs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .vsync_in    (vsync_in),
        .parity_in   (field_parity_in),
        .commit      (commit),
        .parity_sync (parity_sync)
    );

    vcs_cfg_bank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFS_REQ(OFS_REQ), .OFS_FIELD(OFS_FIELD), .OFS_MODE(OFS_MODE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .commit   (commit),
        .work     (work),
        .active   (active),
        .req_pend (req_pend)
    );

    vcs_read_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFS_FIELD(OFS_FIELD), .OFS_MODE(OFS_MODE)
    ) u_rd (
        .addr        (bus_addr),
        .work        (work),
        .live_mode   (active.mode.field_live),
        .parity_sync (parity_sync),
        .rdata       (bus_rdata)
    );

    assign cfg_line_skip   = active.mode.line_skip;
    assign cfg_tile_mode   = active.mode.tile_mode;
    assign cfg_chroma_both = active.mode.chroma_both;
    assign cfg_field_live  = active.mode.field_live;
    assign field_sel       = active.mode.field_live ? parity_sync : active.field_bot;
endmodule

// File: rtl/vcs_shadow_chk.sv
module vcs_shadow_chk
    import vcs_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] OFS_REQ   = 8'h08,
    parameter logic [ADDR_W-1:0] OFS_FIELD = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_MODE  = 8'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              commit,
    input logic              req_pend,
    input cfg_t              work,
    input cfg_t              active
);
    logic wr_req;
    assign wr_req = bus_wr && (bus_addr == OFS_REQ) && bus_wdata[0];

    // R5
    shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && req_pend |=> active == $past(work));
    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && req_pend) |=> $stable(active));
    // R5
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !wr_req |=> !req_pend);
    // R7
    req_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && wr_req |=> req_pend);
    // R4
    req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> req_pend);
    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != OFS_FIELD && bus_addr != OFS_MODE) |-> bus_rdata == '0);
endmodule

bind vid_cfg_shadow_regs vcs_shadow_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_REQ(OFS_REQ), .OFS_FIELD(OFS_FIELD), .OFS_MODE(OFS_MODE)
) i_vcs_shadow_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .commit    (commit),
    .req_pend  (req_pend),
    .work      (work),
    .active    (active)
);

// File: tb/test_vid_cfg_shadow_regs.sv
module test_vid_cfg_shadow_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        vsync_in = 1'b0;
    logic        field_parity_in = 1'b0;
    logic        cfg_line_skip, cfg_tile_mode, cfg_chroma_both, cfg_field_live, field_sel;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_cfg_shadow_regs i_vid_cfg_shadow_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vsync_in(vsync_in),
        .field_parity_in(field_parity_in), .cfg_line_skip(cfg_line_skip),
        .cfg_tile_mode(cfg_tile_mode), .cfg_chroma_both(cfg_chroma_both),
        .cfg_field_live(cfg_field_live), .field_sel(field_sel)
    );

    // ---------------- reference model ----------------
    int m_work_mode, m_work_field, m_act_mode, m_act_field, m_req;
    int vhist[$];
    int p_prev, p_seen;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_work_mode = 0; m_work_field = 0; m_act_mode = 0; m_act_field = 0; m_req = 0;
            vhist = '{0, 0, 0};
            p_prev = 0; p_seen = 0;
        end else begin
            int rise, setr;
            rise = (vhist[1] == 1) && (vhist[2] == 0);
            setr = bus_wr && bus_addr == 8'h08 && bus_wdata[0];
            if (rise && m_req == 1) begin
                m_act_mode  = m_work_mode;
                m_act_field = m_work_field;
            end
            m_req = rise ? setr : (m_req | setr);
            if (bus_wr && bus_addr == 8'h10) m_work_mode  = (bus_wdata >> 2) & 4'hF;
            if (bus_wr && bus_addr == 8'h0C) m_work_field = bus_wdata[0];
            vhist.push_front(int'(vsync_in));
            void'(vhist.pop_back());
            p_seen = p_prev;
            p_prev = field_parity_in;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int live, exp_sel;
            logic [31:0] exp_rd;
            string rtag;
            live    = (m_act_mode & 1);
            exp_sel = live ? p_seen : m_act_field;
            exp_rd  = 0;
            rtag    = "R9";
            if (bus_addr == 8'h10) begin exp_rd = m_work_mode << 2; rtag = "R2"; end
            else if (bus_addr == 8'h0C) begin exp_rd = live ? p_seen : m_work_field; rtag = "R8"; end
            else if (bus_addr == 8'h08) rtag = "R4";
            if (!rst_n) rtag = "R1";
            chk(rtag, bus_rdata, exp_rd);
            chk(rst_n ? "R5 line_skip" : "R1", {31'b0, cfg_line_skip},   (m_act_mode >> 3) & 1);
            chk(rst_n ? "R5 tile"      : "R1", {31'b0, cfg_tile_mode},   (m_act_mode >> 2) & 1);
            chk(rst_n ? "R5 chroma"    : "R1", {31'b0, cfg_chroma_both}, (m_act_mode >> 1) & 1);
            chk(rst_n ? "R6 live"      : "R1", {31'b0, cfg_field_live},  live);
            chk(rst_n ? "R8 field_sel" : "R1", {31'b0, field_sel},       exp_sel);
        end
    end

    // ---------------- stimulus helpers (drive just after posedge) ----------------
    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a);
        bus_addr = a;
        cyc(1);
    endtask

    task automatic vsync_pulse(int hi);
        vsync_in = 1'b1; cyc(hi);
        vsync_in = 1'b0; cyc(4);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R1: reset state on all readbacks
        cyc(2); rd(8'h10); rd(8'h0C); rd(8'h08);
        rst_n = 1'b1; cyc(2);
        rd(8'h10); rd(8'h0C);
        // R2, R3: working readback changes, active does not
        wr(8'h10, 32'hFFFF_FFFF); rd(8'h10); cyc(3);
        // R6: vsync without request
        vsync_pulse(3); rd(8'h10);
        // R4: writing zero does nothing, register reads zero
        wr(8'h08, 32'h0000_0000); rd(8'h08); vsync_pulse(2);
        // R4, R5, R10: arm, then long vsync high
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08);
        vsync_pulse(20);
        // R8: live mode follows parity
        rd(8'h0C);
        field_parity_in = 1'b1; cyc(4);
        field_parity_in = 1'b0; cyc(1);
        field_parity_in = 1'b1; cyc(4);
        // R8: software-chosen field
        wr(8'h10, 32'h0000_0010); wr(8'h0C, 32'h1); wr(8'h08, 32'h1);
        rd(8'h0C); vsync_pulse(2); rd(8'h0C);
        field_parity_in = 1'b0; cyc(4);
        wr(8'h0C, 32'h0); rd(8'h0C);
        // R7: request written in the commit cycle
        wr(8'h10, 32'h0000_0028); wr(8'h08, 32'h1);
        vsync_in = 1'b1; cyc(2);
        wr(8'h08, 32'h1);
        wr(8'h10, 32'h0000_0030);
        vsync_in = 1'b0; cyc(3);
        vsync_pulse(2); rd(8'h10);
        // R9: unmapped offsets
        wr(8'h14, 32'hFFFF_FFFF); wr(8'h09, 32'hFFFF_FFFF); wr(8'h0D, 32'h1);
        rd(8'h14); rd(8'h04); rd(8'h09); rd(8'h10); rd(8'h0C);
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 5);
            case (r)
                0: bus_addr = 8'h08;
                1: bus_addr = 8'h0C;
                2: bus_addr = 8'h10;
                3: bus_addr = 8'h10;
                4: bus_addr = 8'h04;
                default: bus_addr = 8'(($urandom_range(0, 63)));
            endcase
            bus_wr    = ($urandom_range(0, 2) == 0);
            bus_wdata = $urandom;
            if ($urandom_range(0, 6) == 0) vsync_in = ~vsync_in;
            if ($urandom_range(0, 3) == 0) field_parity_in = ~field_parity_in;
            cyc(1);
        end
        bus_wr = 1'b0;
        cyc(4);
        // R1: reset mid-run returns everything to zero
        rst_n = 1'b0; cyc(3);
        rst_n = 1'b1; cyc(2); rd(8'h10);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule